// File: doc/BRIEF.md
# CPU Memory Access Router with External Bus Pin Control

This block sits between a processor core and the memory system of a small handheld-style computer. Each accepted request is decoded by its 16-bit address and sent to exactly one of five buses. These are a hidden boot ROM bus, the external bus (cartridge ROM, cartridge RAM, work RAM and its echo), the internal bus (registers, high RAM, interrupt enable), the video RAM bus, and the object attribute bus. A one-hot bus select reports the chosen bus during the access cycle, together with a valid strobe and the read data.

The block also drives the external bus pins directly. A15 acts as an active-low ROM select. A separate active-low RAM select covers the RAM windows. Both are pulsed for exactly the access cycle. The fifteen low address lines hold their value until an access that updates them. The read and write strobes and the data-direction enable follow a fixed legality rule. A boot overlay flag starts set and maps the lowest 256 bytes to the hidden boot ROM. Software clears it for good by writing one specific value to one register address.

Top module: `cpu_bus_router`

## Requirements
- R1: After reset, the boot flag is 1, valid_o is 0, bus_sel_o is 0, the write strobe is high, the read strobe is low, both chip selects are high, the data enable is 0 and the latched address is 0.
- R2: A request sampled at a rising edge produces valid_o=1 for exactly the following cycle. bus_sel_o is one-hot in that cycle: bit0 hidden boot, bit1 external, bit2 internal, bit3 video RAM, bit4 object attribute. It is 0 when there is no access.
- R3: With the boot flag set, 0x0000-0x00FF selects bit0. With the flag clear, that range selects bit1, as a cartridge ROM access.
- R4: 0x0000-0x7FFF and 0xA000-0xFDFF select bit1. 0x8000-0x9FFF selects bit3. 0xFE00-0xFEFF selects bit4. 0xFF00-0xFFFF selects bit2.
- R5: A write of 0x01 to 0xFF50 clears the boot flag from the next cycle on. A write of any other value, and any write after the flag is clear, leaves the flag as it was.
- R6: ext_a15_n_o is low only in the access cycle of an external access below 0x8000. ext_cs_n_o is low only in the access cycle of an external access in 0xA000-0xFDFF.
- R7: ext_a_o takes addr_i[14:0] on external, internal and object attribute accesses, so an echo-area access drives A13 and A14 high. Hidden-boot and video RAM accesses, and idle cycles, leave it unchanged.
- R8: In an external write cycle, ext_wr_n_o=0, ext_rd_n_o=1, ext_doe_o=1 and ext_d_o equals the write data. In an external read cycle, ext_wr_n_o=1, ext_rd_n_o=0 and ext_doe_o=0. In every other cycle, ext_wr_n_o=1, ext_rd_n_o=0 and ext_doe_o=0.
- R9: ext_doe_o is 1 only while ext_rd_n_o is high and one chip select is low.
- R10: During a read's valid cycle, rdata_o equals ext_d_i for an external access and 0xFF for 0xFEA0-0xFEFF. For every other bus it equals other_rdata_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request, one per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | Access address |
| wdata_i | input | 8 | Write data |
| other_rdata_i | input | 8 | Read data returned by non-external buses |
| ext_d_i | input | 8 | Data pins sampled from the external bus |
| valid_o | output | 1 | Access cycle strobe |
| bus_sel_o | output | 5 | One-hot selected bus |
| rdata_o | output | 8 | Read data to the core |
| boot_active_o | output | 1 | Boot overlay flag |
| ext_wr_n_o | output | 1 | External write strobe, active low |
| ext_rd_n_o | output | 1 | External read strobe, active low |
| ext_cs_n_o | output | 1 | External RAM select, active low |
| ext_a15_n_o | output | 1 | Address line 15, used as ROM select |
| ext_a_o | output | 15 | Latched address lines 0-14 |
| ext_d_o | output | 8 | Data driven onto the external bus |
| ext_doe_o | output | 1 | Data pin output enable |

## Verification
A wrong boot flag shows up in the first access to the low 256 bytes. bus_sel_o then picks the wrong bus in that access's valid cycle, and A15 pulses, or fails to pulse, in that same cycle. A stale or wrongly updated address latch is visible on ext_a_o one cycle after the offending access and in every idle cycle after it. The bench therefore checks the latch in idle gaps, not only in access cycles. A select or strobe left asserted appears in the first idle cycle after an access, where every pin must return to its resting level.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
    localparam int ADDR_W  = 16;
    localparam int DATA_W  = 8;
    localparam int NUM_BUS = 5;
    localparam int LOW_W   = ADDR_W - 1;

    localparam int BUS_BOOT  = 0;
    localparam int BUS_EXT   = 1;
    localparam int BUS_INT   = 2;
    localparam int BUS_VRAM  = 3;
    localparam int BUS_OBJ   = 4;

    typedef struct packed {
        logic [NUM_BUS-1:0] sel;
        logic               rom;
        logic               ram;
        logic               upd_addr;
        logic               unused;
    } dec_t;
endpackage

// File: rtl/cbr_decode.sv
module cbr_decode
    import cbr_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BOOT_TOP  = 16'h00FF,
    parameter logic [ADDR_W-1:0] VRAM_LO   = 16'h8000,
    parameter logic [ADDR_W-1:0] VRAM_HI   = 16'h9FFF,
    parameter logic [ADDR_W-1:0] RAM_HI    = 16'hFDFF,
    parameter logic [ADDR_W-1:0] OBJ_HI    = 16'hFEFF,
    parameter logic [ADDR_W-1:0] OBJ_REAL  = 16'hFE9F
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              boot_i,
    output dec_t              dec_o
);
    always_comb begin
        dec_o = '0;
        if (boot_i && addr_i <= BOOT_TOP) begin
            dec_o.sel[BUS_BOOT] = 1'b1;
        end else if (addr_i < VRAM_LO) begin
            dec_o.sel[BUS_EXT]  = 1'b1;
            dec_o.rom           = 1'b1;
            dec_o.upd_addr      = 1'b1;
        end else if (addr_i <= VRAM_HI) begin
            dec_o.sel[BUS_VRAM] = 1'b1;
        end else if (addr_i <= RAM_HI) begin
            dec_o.sel[BUS_EXT]  = 1'b1;
            dec_o.ram           = 1'b1;
            dec_o.upd_addr      = 1'b1;
        end else if (addr_i <= OBJ_HI) begin
            dec_o.sel[BUS_OBJ]  = 1'b1;
            dec_o.upd_addr      = 1'b1;
            dec_o.unused        = (addr_i > OBJ_REAL);
        end else begin
            dec_o.sel[BUS_INT]  = 1'b1;
            dec_o.upd_addr      = 1'b1;
        end
    end
endmodule

// File: rtl/cbr_boot_flag.sv
module cbr_boot_flag
    import cbr_pkg::*;
#(
    parameter logic [ADDR_W-1:0] OFF_ADDR = 16'hFF50,
    parameter logic [DATA_W-1:0] OFF_VAL  = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              boot_o
);
    logic boot_d, boot_q;

    always_comb begin
        boot_d = boot_q;
        if (wr_i && addr_i == OFF_ADDR && wdata_i == OFF_VAL)
            boot_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) boot_q <= 1'b1;
        else        boot_q <= boot_d;
    end

    assign boot_o = boot_q;
endmodule

// File: rtl/cpu_bus_router.sv
module cpu_bus_router
    import cbr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] other_rdata_i,
    input  logic [DATA_W-1:0] ext_d_i,
    output logic              valid_o,
    output logic [NUM_BUS-1:0] bus_sel_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              boot_active_o,
    output logic              ext_wr_n_o,
    output logic              ext_rd_n_o,
    output logic              ext_cs_n_o,
    output logic              ext_a15_n_o,
    output logic [LOW_W-1:0]  ext_a_o,
    output logic [DATA_W-1:0] ext_d_o,
    output logic              ext_doe_o
);
    typedef struct packed {
        logic               valid;
        logic [NUM_BUS-1:0] sel;
        logic               unused;
        logic               wr_n;
        logic               rd_n;
        logic               cs_n;
        logic               a15_n;
        logic [LOW_W-1:0]   a;
        logic [DATA_W-1:0]  d;
        logic               doe;
    } pin_t;

    pin_t st_d, st_q;
    dec_t dec;
    logic boot;

    cbr_decode u_decode (
        .addr_i (addr_i),
        .boot_i (boot),
        .dec_o  (dec)
    );

    cbr_boot_flag u_boot (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (req_i && we_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .boot_o  (boot)
    );

    always_comb begin
        st_d        = st_q;
        st_d.valid  = 1'b0;
        st_d.sel    = '0;
        st_d.unused = 1'b0;
        st_d.wr_n   = 1'b1;
        st_d.rd_n   = 1'b0;
        st_d.cs_n   = 1'b1;
        st_d.a15_n  = 1'b1;
        st_d.doe    = 1'b0;
        if (req_i) begin
            st_d.valid  = 1'b1;
            st_d.sel    = dec.sel;
            st_d.unused = dec.unused;
            if (dec.upd_addr)
                st_d.a = addr_i[LOW_W-1:0];
            if (dec.sel[BUS_EXT]) begin
                st_d.a15_n = ~dec.rom;
                st_d.cs_n  = ~dec.ram;
                if (we_i) begin
                    st_d.wr_n = 1'b0;
                    st_d.rd_n = 1'b1;
                    st_d.doe  = 1'b1;
                    st_d.d    = wdata_i;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.wr_n  <= 1'b1;
            st_q.cs_n  <= 1'b1;
            st_q.a15_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (st_q.sel[BUS_EXT])  rdata_o = ext_d_i;
        else if (st_q.unused)   rdata_o = '1;
        else                    rdata_o = other_rdata_i;
    end

    assign valid_o       = st_q.valid;
    assign bus_sel_o     = st_q.sel;
    assign boot_active_o = boot;
    assign ext_wr_n_o    = st_q.wr_n;
    assign ext_rd_n_o    = st_q.rd_n;
    assign ext_cs_n_o    = st_q.cs_n;
    assign ext_a15_n_o   = st_q.a15_n;
    assign ext_a_o       = st_q.a;
    assign ext_d_o       = st_q.d;
    assign ext_doe_o     = st_q.doe;
endmodule

// File: rtl/cpu_bus_router_chk.sv
module cpu_bus_router_chk
    import cbr_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               req_i,
    input logic               valid_o,
    input logic [NUM_BUS-1:0] bus_sel_o,
    input logic               boot_active_o,
    input logic               ext_rd_n_o,
    input logic               ext_wr_n_o,
    input logic               ext_cs_n_o,
    input logic               ext_a15_n_o,
    input logic [LOW_W-1:0]   ext_a_o,
    input logic               ext_doe_o
);
    // R2
    valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(req_i));
    // R2
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bus_sel_o) && (valid_o == (bus_sel_o != '0)));
    // R5
    boot_stays_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !boot_active_o |=> !boot_active_o);
    // R6
    rom_sel_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_a15_n_o |-> (valid_o && bus_sel_o[BUS_EXT] && ext_cs_n_o));
    // R6
    ram_sel_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_cs_n_o |-> (valid_o && bus_sel_o[BUS_EXT] && ext_a15_n_o));
    // R7
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_o || bus_sel_o[BUS_BOOT] || bus_sel_o[BUS_VRAM]) |-> $stable(ext_a_o));
    // R8
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_wr_n_o |-> (ext_rd_n_o && bus_sel_o[BUS_EXT]));
    // R9
    doe_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_doe_o |-> (ext_rd_n_o && (!ext_cs_n_o || !ext_a15_n_o)));
endmodule

bind cpu_bus_router cpu_bus_router_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_i         (req_i),
    .valid_o       (valid_o),
    .bus_sel_o     (bus_sel_o),
    .boot_active_o (boot_active_o),
    .ext_rd_n_o    (ext_rd_n_o),
    .ext_wr_n_o    (ext_wr_n_o),
    .ext_cs_n_o    (ext_cs_n_o),
    .ext_a15_n_o   (ext_a15_n_o),
    .ext_a_o       (ext_a_o),
    .ext_doe_o     (ext_doe_o)
);

// File: tb/cpu_bus_router_tb.sv
module cpu_bus_router_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0, we_i = 1'b0;
    logic [15:0] addr_i = '0;
    logic [7:0]  wdata_i = '0, other_rdata_i = '0, ext_d_i = '0;
    logic        valid_o, boot_active_o;
    logic [4:0]  bus_sel_o;
    logic [7:0]  rdata_o, ext_d_o;
    logic        ext_wr_n_o, ext_rd_n_o, ext_cs_n_o, ext_a15_n_o, ext_doe_o;
    logic [14:0] ext_a_o;

    int total = 0, bad = 0;
    logic        exp_boot = 1'b1;
    logic [14:0] exp_a = '0;
    logic [7:0]  exp_d = '0;

    always #5 clk = ~clk;

    cpu_bus_router dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .other_rdata_i(other_rdata_i), .ext_d_i(ext_d_i),
        .valid_o(valid_o), .bus_sel_o(bus_sel_o), .rdata_o(rdata_o),
        .boot_active_o(boot_active_o), .ext_wr_n_o(ext_wr_n_o),
        .ext_rd_n_o(ext_rd_n_o), .ext_cs_n_o(ext_cs_n_o),
        .ext_a15_n_o(ext_a15_n_o), .ext_a_o(ext_a_o), .ext_d_o(ext_d_o),
        .ext_doe_o(ext_doe_o)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic logic [4:0] exp_sel(input logic [15:0] a, input logic boot);
        if (boot && a <= 16'h00FF)  return 5'b00001;
        if (a < 16'h8000)           return 5'b00010;
        if (a < 16'hA000)           return 5'b01000;
        if (a < 16'hFE00)           return 5'b00010;
        if (a < 16'hFF00)           return 5'b10000;
        return 5'b00100;
    endfunction

    task automatic check_idle();
        chk(valid_o == 1'b0 && bus_sel_o == 5'd0, "R2 idle valid/sel", {valid_o, bus_sel_o}, 0);
        chk(ext_wr_n_o && !ext_rd_n_o && !ext_doe_o, "R8 idle strobes",
            {ext_wr_n_o, ext_rd_n_o, ext_doe_o}, 3'b100);
        chk(ext_cs_n_o && ext_a15_n_o, "R6 idle selects", {ext_cs_n_o, ext_a15_n_o}, 2'b11);
        chk(ext_a_o == exp_a, "R7 idle address hold", ext_a_o, exp_a);
        chk(boot_active_o == exp_boot, "R5 boot flag", boot_active_o, exp_boot);
    endtask

    task automatic access(input logic we, input logic [15:0] a, input logic [7:0] wd,
                          input logic idle_after);
        logic [4:0] es;
        logic [7:0] xd, od, er;
        logic       rom, ram;
        @(negedge clk);
        xd = 8'($urandom); od = 8'($urandom);
        req_i = 1'b1; we_i = we; addr_i = a; wdata_i = wd;
        ext_d_i = xd; other_rdata_i = od;
        es  = exp_sel(a, exp_boot);
        rom = es[1] && a < 16'h8000;
        ram = es[1] && a >= 16'hA000;
        if (es[1] || es[2] || es[4]) exp_a = a[14:0];
        if (es[1] && we) exp_d = wd;
        @(negedge clk);
        req_i = 1'b0;
        if (we && a == 16'hFF50 && wd == 8'h01) exp_boot = 1'b0;
        chk(valid_o, "R2 valid", valid_o, 1);
        chk(bus_sel_o == es, "R3/R4 bus select", bus_sel_o, es);
        chk(ext_a15_n_o == !rom, "R6 rom select", ext_a15_n_o, !rom);
        chk(ext_cs_n_o == !ram, "R6 ram select", ext_cs_n_o, !ram);
        chk(ext_a_o == exp_a, "R7 address", ext_a_o, exp_a);
        if (es[1] && we) begin
            chk(!ext_wr_n_o && ext_rd_n_o && ext_doe_o && ext_d_o == exp_d,
                "R8 ext write", {ext_wr_n_o, ext_rd_n_o, ext_doe_o, ext_d_o}, {3'b011, exp_d});
        end else begin
            chk(ext_wr_n_o && !ext_rd_n_o && !ext_doe_o, "R8 non-write strobes",
                {ext_wr_n_o, ext_rd_n_o, ext_doe_o}, 3'b100);
        end
        chk(!ext_doe_o || (ext_rd_n_o && (!ext_cs_n_o || !ext_a15_n_o)), "R9 doe rule",
            ext_doe_o, 0);
        if (!we) begin
            er = es[1] ? xd : ((a >= 16'hFEA0 && a <= 16'hFEFF) ? 8'hFF : od);
            chk(rdata_o == er, "R10 read data", rdata_o, er);
        end
        chk(boot_active_o == exp_boot, "R5 boot flag", boot_active_o, exp_boot);
        if (idle_after) begin
            @(negedge clk);
            check_idle();
        end
    endtask

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seed_v;
        seed_v = $urandom(32'd4711);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(boot_active_o == 1'b1, "R1 boot flag reset", boot_active_o, 1);
        check_idle();
        rst_n = 1'b1;
        @(negedge clk);
        check_idle();
        // directed: R3 hidden boot range keeps address latch (R7)
        access(1'b0, 16'h1234, 8'h00, 1'b1);
        access(1'b0, 16'h0050, 8'h00, 1'b1);
        access(1'b0, 16'h00FF, 8'h00, 1'b0);
        access(1'b0, 16'h0100, 8'h00, 1'b1);
        // R7 video RAM leaves latch, echo sets A13/A14
        access(1'b1, 16'h9ABC, 8'h55, 1'b1);
        access(1'b1, 16'hE123, 8'hA5, 1'b1);
        chk(ext_a_o[14:13] == 2'b11, "R7 echo A13/A14", ext_a_o[14:13], 3);
        // R4 edges, R10 unused area
        access(1'b0, 16'hFDFF, 8'h00, 1'b0);
        access(1'b0, 16'hFE9F, 8'h00, 1'b0);
        access(1'b0, 16'hFEA0, 8'h00, 1'b0);
        access(1'b0, 16'hFEFF, 8'h00, 1'b1);
        access(1'b0, 16'hFFFF, 8'h00, 1'b1);
        access(1'b0, 16'h7FFF, 8'h00, 1'b0);
        access(1'b0, 16'hA000, 8'h00, 1'b1);
        // R5: other values do not clear
        access(1'b1, 16'hFF50, 8'h02, 1'b1);
        access(1'b1, 16'hFF50, 8'h00, 1'b1);
        access(1'b0, 16'hFF50, 8'h01, 1'b1);
        access(1'b0, 16'h0010, 8'h00, 1'b1);
        // R5 clear, then R3 boot range goes to cartridge ROM
        access(1'b1, 16'hFF50, 8'h01, 1'b1);
        access(1'b0, 16'h0010, 8'h00, 1'b1);
        access(1'b1, 16'h00F0, 8'h3C, 1'b1);
        access(1'b1, 16'hFF50, 8'h00, 1'b1);
        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [15:0] ra;
            case ($urandom % 6)
                0: ra = 16'($urandom % 16'h8000);
                1: ra = 16'h8000 + 16'($urandom % 16'h2000);
                2: ra = 16'hA000 + 16'($urandom % 16'h5E00);
                3: ra = 16'hFE00 + 16'($urandom % 16'h100);
                4: ra = 16'hFF00 + 16'($urandom % 16'h100);
                default: ra = 16'($urandom % 16'h100);
            endcase
            access(1'($urandom), ra, 8'($urandom), 1'($urandom));
        end
        @(negedge clk);
        check_idle();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule